// File: doc/BRIEF.md
# Serial Transceiver Datapath with Loopbacks

This block is the bit-level datapath of a transceiver. On the transmit side it has a loadable shift register. Every sixteenth bit clock it takes a half-word from the transmit FIFO and sends it out most significant bit first, one bit per clock. On the receive side a serial-in shifter gathers incoming bits, and an output register shows each completed half-word on a parallel bus. A divided parallel clock runs beside the bus. Its falling edge marks the moment a new half-word is presented.

Two loopback paths can be used for test. Each can be enabled on its own, and both can be on at once. The diagnostic path is enabled by an active-low input. It feeds the internal transmit bit stream into the receive shifter in place of the line input, and it overrides the signal-detect input. The line path is active high. It drives the received serial input straight back out on the transmit serial pin. The whole block runs from one bit clock, and the receive clock and transmit clock are assumed to be the same. Reset is synchronous and active low.

Top module: `serdes_lb`

## Requirements
- R1: `tx_load` is high for exactly one clock in every 16. It is first high in the first clock after reset is released, and it is low during reset. The shifter captures `tx_word` on each clock edge where `tx_load` is high.
- R2: Outside line loopback, `tx_ser` carries the loaded half-word most significant bit first: bit 15 in the clock after the load edge, then bit 14, down to bit 0. Before the first load the output is 0.
- R3: The receive shifter samples its input bit on every clock. On every 16th edge after reset (edges 16, 32, …), `rx_word` takes the last 16 sampled bits, with the earliest bit in bit 15. At no other edge does `rx_word` change.
- R4: `rx_pclk` is low for the first 8 clocks of each 16-clock receive frame and high for the last 8. It falls exactly at the edge where `rx_word` updates, and that edge is also a transmit load edge.
- R5: With `line_lb` = 1, `tx_ser` equals `rx_ser` combinationally, whatever the transmit shifter holds.
- R6: With `diag_lb_n` = 0, the receive shifter samples the internal transmit bit stream. `rx_ser` and `sig_det` have no effect on `rx_word` while this holds.
- R7: With `diag_lb_n` = 1 and `sig_det` = 0, the receive shifter samples 0. With `sig_det` = 1, it samples `rx_ser`.
- R8: With `diag_lb_n` = 0 and `line_lb` = 1 together, `tx_ser` follows `rx_ser`, and the receive shifter still samples the internal transmit stream, not the pin.
- R9: While `rst_n` is low at a clock edge, `rx_word`, `rx_pclk` and the internal transmit bit are cleared to 0, and both frame counters restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock for both directions |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_word | input | 16 | Half-word from the transmit FIFO |
| tx_load | output | 1 | Load strobe, one clock in 16 |
| tx_ser | output | 1 | Transmit serial output |
| rx_ser | input | 1 | Received serial input |
| sig_det | input | 1 | Signal present on the line, active high |
| diag_lb_n | input | 1 | Diagnostic loopback enable, active low |
| line_lb | input | 1 | Line loopback enable, active high |
| rx_word | output | 16 | Received half-word |
| rx_pclk | output | 1 | Parallel output clock, divide by 16 |

## Verification
Suppose a frame counter slips or the shifters start one clock off. The error then shows at the ports within one 16-clock frame: a misplaced `tx_load` pulse, a `tx_ser` stream rotated by one bit, or an `rx_word` whose bits are shifted. A wrong loopback select shows in the very next clock on `tx_ser`, or by the next `rx_pclk` fall on `rx_word`. The bench compares every port on every clock against a bit-queue model. That model is run through normal traffic, lost signal, diagnostic loopback with the pin toggling, line loopback, both loopbacks together, and a reset in mid-frame.

// File: rtl/serdes_lb_pkg.sv
// Package: shared types for the serial datapath.
// Names which source feeds the receive shifter.
package serdes_lb_pkg;
    typedef enum logic [1:0] {
        RXSRC_PIN  = 2'd0,
        RXSRC_TX   = 2'd1,
        RXSRC_ZERO = 2'd2
    } rx_src_e;
endpackage

// File: rtl/serdes_tx_shift.sv
// Transmit shifter: a frame counter makes a one-clock load strobe every W
// clocks. On that edge the W-bit register loads the parallel word. On the
// other edges it shifts left, so the MSB leaves first.
// Assumes W is a power of two and at least 4.
module serdes_tx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_in,
    output logic         load,
    output logic         bit_out
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;
    logic [W-1:0]  shreg;

    // Load strobe: first frame clock, held off during reset.
    assign load    = rst_n && (cnt == '0);
    assign bit_out = shreg[W-1];

    // Frame counter that wraps every W clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Load the parallel word on the strobe, otherwise shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg <= '0;
        else if (load) shreg <= word_in;
        else           shreg <= {shreg[W-2:0], 1'b0};
    end

    // R1: the strobe never lasts more than one clock.
    a_r1_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // R2: between loads the serial bit walks down the register by one place.
    a_r2_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (bit_out == $past(shreg[W-2])));
endmodule

// File: rtl/serdes_rx_deser.sv
// Receive deserializer: it shifts one bit per clock into a W-bit shifter.
// At the last edge of each W-clock frame it copies the completed word into
// the output register. The divided clock is the counter MSB, so it falls at
// that same edge.
// Assumes W is a power of two and at least 4.
module serdes_rx_deser #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    output logic [W-1:0] word_out,
    output logic         pclk
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;
    logic [W-1:0]  shreg;
    logic          frame_end;

    assign frame_end = (cnt == CW'(W - 1));
    assign pclk      = cnt[CW-1];

    // Bit counter for the receive frame.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Serial-in shifter: the earliest bit ends up in the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[W-2:0], bit_in};
    end

    // Output register: takes the completed word at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         word_out <= '0;
        else if (frame_end) word_out <= {shreg[W-2:0], bit_in};
    end

    // R3/R4: the output word changes only when the divided clock falls.
    a_r4_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(pclk) |-> $stable(word_out));
endmodule

// File: rtl/serdes_loop_mux.sv
// Loopback selection: picks the bit that feeds the receive shifter and the
// bit that drives the transmit pin. The diagnostic enable wins over the
// signal detect. The line loopback only affects the transmit pin.
module serdes_loop_mux
    import serdes_lb_pkg::*;
(
    input  logic diag_lb_n,
    input  logic line_lb,
    input  logic sig_det,
    input  logic rx_pin,
    input  logic tx_bit,
    output logic rx_bit,
    output logic tx_pin
);
    rx_src_e src;

    // Source priority: diagnostic loopback, then signal detect, then zero.
    always_comb begin
        if (!diag_lb_n)   src = RXSRC_TX;
        else if (sig_det) src = RXSRC_PIN;
        else              src = RXSRC_ZERO;
    end

    // Receive input select.
    always_comb begin
        case (src)
            RXSRC_TX:  rx_bit = tx_bit;
            RXSRC_PIN: rx_bit = rx_pin;
            default:   rx_bit = 1'b0;
        endcase
    end

    // Transmit pin: the line loopback replaces the internal stream.
    assign tx_pin = line_lb ? rx_pin : tx_bit;
endmodule

// File: rtl/serdes_lb.sv
// Top of the serial datapath: the transmit shifter, the receive
// deserializer and the loopback selection. All parts share one bit clock.
// The two frame counters leave reset together, so they stay aligned.
module serdes_lb #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tx_word,
    output logic         tx_load,
    output logic         tx_ser,
    input  logic         rx_ser,
    input  logic         sig_det,
    input  logic         diag_lb_n,
    input  logic         line_lb,
    output logic [W-1:0] rx_word,
    output logic         rx_pclk
);
    logic tx_bit;
    logic rx_bit;

    serdes_tx_shift #(.W(W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_in (tx_word),
        .load    (tx_load),
        .bit_out (tx_bit)
    );

    serdes_loop_mux u_mux (
        .diag_lb_n (diag_lb_n),
        .line_lb   (line_lb),
        .sig_det   (sig_det),
        .rx_pin    (rx_ser),
        .tx_bit    (tx_bit),
        .rx_bit    (rx_bit),
        .tx_pin    (tx_ser)
    );

    serdes_rx_deser #(.W(W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (rx_bit),
        .word_out (rx_word),
        .pclk     (rx_pclk)
    );

    // R4: the receive frame ends on the same edge as a transmit load.
    a_r4_frame_align: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_pclk) |-> tx_load);

    // R1: the first clock after reset is released is a load clock.
    a_r1_first_load: assert property (@(posedge clk)
        (!rst_n) |=> (rst_n -> tx_load));
endmodule

// File: tb/serdes_lb_test.sv
`timescale 1ns/1ps
module serdes_lb_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] tx_word;
    logic        tx_load, tx_ser, rx_ser, sig_det, diag_lb_n, line_lb;
    logic [15:0] rx_word;
    logic        rx_pclk;

    int tests = 0;
    int fails = 0;

    // Behavioural model state.
    int          edges;
    bit          tx_cur;
    bit          txq[$];
    logic [15:0] hist, exp_word;

    always #2.5 clk = ~clk;

    serdes_lb uut (
        .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .tx_load(tx_load),
        .tx_ser(tx_ser), .rx_ser(rx_ser), .sig_det(sig_det),
        .diag_lb_n(diag_lb_n), .line_lb(line_lb), .rx_word(rx_word),
        .rx_pclk(rx_pclk)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    // Advance the model over one rising edge, using the inputs applied now.
    task automatic model_edge();
        bit rin;
        if (!rst_n) begin
            edges = 0; tx_cur = 0; txq.delete(); hist = 0; exp_word = 0;
            return;
        end
        if (!diag_lb_n)   rin = tx_cur;
        else if (sig_det) rin = rx_ser;
        else              rin = 1'b0;
        hist = {hist[14:0], rin};
        if (edges % 16 == 15) exp_word = hist;
        if (edges % 16 == 0) begin
            txq.delete();
            for (int i = 15; i >= 0; i--) txq.push_back(tx_word[i]);
        end
        tx_cur = txq.pop_front();
        edges++;
    endtask

    // Compare every port against the model.
    task automatic check_all(input bit in_reset);
        string rtag, ttag;
        logic  exp_ser;
        exp_ser = line_lb ? rx_ser : tx_cur;
        if (in_reset)                  rtag = "R9";
        else if (!diag_lb_n && line_lb) rtag = "R8";
        else if (!diag_lb_n)           rtag = "R6";
        else if (!sig_det)             rtag = "R7";
        else                           rtag = "R3";
        if (in_reset)                  ttag = "R9";
        else if (line_lb && !diag_lb_n) ttag = "R8";
        else if (line_lb)              ttag = "R5";
        else                           ttag = "R2";
        check(in_reset ? "R9" : "R1", "tx_load", 16'(tx_load),
              16'(rst_n && (edges % 16 == 0)));
        check(ttag, "tx_ser", 16'(tx_ser), 16'(exp_ser));
        check(rtag, "rx_word", rx_word, exp_word);
        check(in_reset ? "R9" : "R4", "rx_pclk", 16'(rx_pclk),
              16'((edges % 16) >= 8));
    endtask

    // Run n clocks with the given modes; drive on the falling edge.
    task automatic run(input int n, input bit rst, input bit sd,
                       input bit dn, input bit ll);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            check_all(!rst_n);
            rst_n     = rst;
            sig_det   = sd;
            diag_lb_n = dn;
            line_lb   = ll;
            tx_word   = 16'($urandom);
            rx_ser    = 1'($urandom);
            model_edge();
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 0; sig_det = 1; diag_lb_n = 1; line_lb = 0;
        tx_word = 16'hA5C3; rx_ser = 0;
        model_edge();
        run(3,   0, 1, 1, 0);  // R9 reset
        run(100, 1, 1, 1, 0);  // R1 R2 R3 R4 normal
        run(64,  1, 0, 1, 0);  // R7 no signal
        run(50,  1, 0, 0, 0);  // R6 diag, signal off
        run(50,  1, 1, 0, 0);  // R6 diag overrides signal detect
        run(64,  1, 1, 1, 1);  // R5 line loopback
        run(100, 1, 0, 0, 1);  // R8 both loopbacks
        run(7,   1, 1, 1, 0);
        run(3,   0, 1, 1, 0);  // R9 mid-frame reset
        run(48,  1, 1, 1, 0);  // R1 R3 after reset
        @(negedge clk);
        check_all(1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule